// File: doc/BRIEF.md
# Shared-Line Transmit Arbiter

This block decides when one station may transmit on a serial line that several stations share. The line is wired-AND: a station sends a 0 by pulling the line low and sends a 1 by releasing it, so any low driver wins. All stations run from one common bit clock. The arbiter sits between a serial frame generator and the open-drain pin. It watches the real line level on a dedicated sense input, and it only begins once the line has been high for a run of consecutive bit times.

During a frame the arbiter drives the line one bit per bit period and asks the generator for each next bit with a one-cycle ready strobe. At the end of every bit period it compares the level it drove with the level it sensed. If it released the line for a 1 but sensed a 0, another station has won. The arbiter then flags a collision, lets go of the line, drops the rest of the frame and goes back to waiting. It retries on its own for as long as the request stays high.

After it finishes a frame of its own, the station takes a longer idle requirement for its next attempt only. This gives the other stations a fair turn on the line.

Top module: `hdlc_bus_arbiter`

## Requirements
- R1: While reset is low and after it is released, driveLow, txOn, collision, done and bitReady are all 0.
- R2: While txReq is 0 and no frame is in progress, txOn stays 0 and the line is never pulled low.
- R3: With no back-off pending, a frame starts on the bit strobe that samples the 8th consecutive high line level, counting that strobe. txOn rises right after that strobe edge. If the line has already been high long enough, the start comes on the first strobe with txReq high.
- R4: A low line level sampled on a strobe while waiting restarts the consecutive-high count from zero.
- R5: After a frame of its own ends with done, the next start needs 10 consecutive high samples. That longer need is cleared once the next frame starts.
- R6: While txOn is 1, driveLow is 1 exactly for the bit periods that carry a 0 bit, and it is 0 for 1 bits. driveLow and txOn change only on bit-strobe edges.
- R7: bitReady is 1 only in a cycle where bitEn is 1. On that edge the arbiter takes txBit/txLast as the next bit to drive, so bits go out in the order the generator gives them.
- R8: If a 1 bit period ends with the line sensed low, collision is 1 for exactly one clock, txOn and driveLow are 0 from that edge onward, and no further bit of the frame is driven.
- R9: A bit period that sends a 0 while the line is low does not count as a collision, and the frame goes on.
- R10: After the bit period marked by txLast ends without a collision, done is 1 for exactly one clock and the line is released.
- R11: After a collision with txReq still 1, the arbiter retries by itself and needs only 8 consecutive high samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitEn | input | 1 | One-cycle strobe at the end of each bit period |
| txReq | input | 1 | Frame generator has a frame to send |
| txBit | input | 1 | Next bit offered by the frame generator |
| txLast | input | 1 | Offered bit is the final bit of the frame |
| bitReady | output | 1 | Offered bit is taken on this edge |
| busSense | input | 1 | Sensed level of the shared line (1 = high) |
| driveLow | output | 1 | Pull the open-drain line low |
| txOn | output | 1 | Arbiter currently owns the line |
| collision | output | 1 | One-clock pulse: arbitration lost |
| done | output | 1 | One-clock pulse: frame completed |

## Verification
The bench measures the exact number of strobes waited in several situations. These are a line already idle, a plain 8-count after a lost arbitration, a 10-count right after its own success, and counts broken by a low sample part way through. A design that counted the strobes off by one would be caught, and so would one that kept the back-off longer than one attempt or did not restart the count. Collisions are forced on a middle bit and on a single-bit frame. A matching low from another station is placed on 0 bits. A design that flagged any mismatch, or kept driving after losing, would show extra bits or a missing collision pulse in the scoreboard.

// File: rtl/hdlc_arb_pkg.sv
package hdlc_arb_pkg;

  typedef enum logic [0:0] {
    ST_WAIT = 1'b0,
    ST_SEND = 1'b1
  } arbState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntIdle;     // advance idle counter with sampled level
    logic clrIdle;     // clear idle counter
    logic loadBit;     // capture next bit from framer
    logic setBackoff;  // arm long idle requirement
    logic clrBackoff;  // drop long idle requirement
  } dpCtrl_t;

endpackage

// File: rtl/hdlc_arb_dp.sv
module hdlc_arb_dp
  import hdlc_arb_pkg::*;
#(
  parameter int IDLE_NORMAL  = 8,
  parameter int IDLE_BACKOFF = 10
) (
  input  logic    clk,
  input  logic    rstN,
  input  dpCtrl_t ctl,
  input  logic    sending,
  input  logic    txBit,
  input  logic    txLast,
  input  logic    busSense,
  output logic    idleMet,
  output logic    mismatch,
  output logic    curLast,
  output logic    driveLow
);

  localparam int CNT_MAXV = (IDLE_BACKOFF > IDLE_NORMAL) ? IDLE_BACKOFF : IDLE_NORMAL;
  localparam int CNT_W    = $clog2(CNT_MAXV + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(CNT_MAXV);
  localparam logic [CNT_W-1:0] NEED_LO  = CNT_W'(IDLE_NORMAL);
  localparam logic [CNT_W-1:0] NEED_HI  = CNT_W'(IDLE_BACKOFF);

  logic [CNT_W-1:0] idleCnt;
  logic [CNT_W-1:0] nextCnt;
  logic [CNT_W-1:0] idleNeed;
  logic             backoff;
  logic             curBit;

  // count including the level sampled on this strobe, saturating
  always_comb begin
    if (!busSense)            nextCnt = '0;
    else if (idleCnt == CNT_MAX) nextCnt = CNT_MAX;
    else                      nextCnt = idleCnt + 1'b1;
  end

  assign idleNeed = backoff ? NEED_HI : NEED_LO;
  assign idleMet  = (nextCnt >= idleNeed);
  assign mismatch = curBit && !busSense;
  assign driveLow = sending && !curBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idleCnt <= '0;
    end else if (ctl.clrIdle) begin
      idleCnt <= '0;
    end else if (ctl.cntIdle) begin
      idleCnt <= nextCnt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      backoff <= 1'b0;
    end else if (ctl.setBackoff) begin
      backoff <= 1'b1;
    end else if (ctl.clrBackoff) begin
      backoff <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curBit  <= 1'b1;
      curLast <= 1'b0;
    end else if (ctl.loadBit) begin
      curBit  <= txBit;
      curLast <= txLast;
    end
  end

endmodule

// File: rtl/hdlc_arb_ctrl.sv
module hdlc_arb_ctrl
  import hdlc_arb_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    bitEn,
  input  logic    txReq,
  input  logic    idleMet,
  input  logic    mismatch,
  input  logic    curLast,
  output dpCtrl_t ctl,
  output logic    sending,
  output logic    bitReady,
  output logic    collision,
  output logic    done
);

  arbState_t state, nextState;
  logic      collNext;
  logic      doneNext;

  always_comb begin
    ctl       = '0;
    nextState = state;
    bitReady  = 1'b0;
    collNext  = 1'b0;
    doneNext  = 1'b0;
    case (state)
      ST_WAIT: begin
        if (bitEn) begin
          if (txReq && idleMet) begin
            ctl.loadBit    = 1'b1;
            ctl.clrBackoff = 1'b1;
            ctl.clrIdle    = 1'b1;
            bitReady       = 1'b1;
            nextState      = ST_SEND;
          end else begin
            ctl.cntIdle = 1'b1;
          end
        end
      end
      ST_SEND: begin
        if (bitEn) begin
          if (mismatch) begin
            ctl.clrIdle = 1'b1;
            collNext    = 1'b1;
            nextState   = ST_WAIT;
          end else if (curLast) begin
            ctl.clrIdle    = 1'b1;
            ctl.setBackoff = 1'b1;
            doneNext       = 1'b1;
            nextState      = ST_WAIT;
          end else begin
            ctl.loadBit = 1'b1;
            bitReady    = 1'b1;
          end
        end
      end
      default: nextState = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_WAIT;
      collision <= 1'b0;
      done      <= 1'b0;
    end else begin
      state     <= nextState;
      collision <= collNext;
      done      <= doneNext;
    end
  end

  assign sending = (state == ST_SEND);

endmodule

// File: rtl/hdlc_bus_arbiter.sv
module hdlc_bus_arbiter
  import hdlc_arb_pkg::*;
#(
  parameter int IDLE_NORMAL  = 8,
  parameter int IDLE_BACKOFF = 10
) (
  input  logic clk,
  input  logic rstN,
  input  logic bitEn,
  input  logic txReq,
  input  logic txBit,
  input  logic txLast,
  output logic bitReady,
  input  logic busSense,
  output logic driveLow,
  output logic txOn,
  output logic collision,
  output logic done
);

  dpCtrl_t ctl;
  logic    idleMet;
  logic    mismatch;
  logic    curLast;

  hdlc_arb_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .bitEn     (bitEn),
    .txReq     (txReq),
    .idleMet   (idleMet),
    .mismatch  (mismatch),
    .curLast   (curLast),
    .ctl       (ctl),
    .sending   (txOn),
    .bitReady  (bitReady),
    .collision (collision),
    .done      (done)
  );

  hdlc_arb_dp #(
    .IDLE_NORMAL  (IDLE_NORMAL),
    .IDLE_BACKOFF (IDLE_BACKOFF)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .sending  (txOn),
    .txBit    (txBit),
    .txLast   (txLast),
    .busSense (busSense),
    .idleMet  (idleMet),
    .mismatch (mismatch),
    .curLast  (curLast),
    .driveLow (driveLow)
  );

endmodule

// File: rtl/hdlc_arb_checker.sv
module hdlc_arb_checker (
  input logic clk,
  input logic rstN,
  input logic bitEn,
  input logic txReq,
  input logic busSense,
  input logic bitReady,
  input logic driveLow,
  input logic txOn,
  input logic collision,
  input logic done
);

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |=> (!txOn && !driveLow && !collision && !done));

  p_no_req_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!txOn && !txReq) |=> !txOn);

  p_start_on_high_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txOn) |-> $past(bitEn && busSense && txReq));

  p_drive_owned_r6: assert property (@(posedge clk) disable iff (!rstN)
    driveLow |-> txOn);

  p_edge_only_r6: assert property (@(posedge clk) disable iff (!rstN)
    !bitEn |=> ($stable(txOn) && $stable(driveLow)));

  p_ready_strobe_r7: assert property (@(posedge clk) disable iff (!rstN)
    bitReady |-> bitEn);

  p_coll_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    collision |-> $past(bitEn && txOn && !driveLow && !busSense));

  p_coll_release_r8: assert property (@(posedge clk) disable iff (!rstN)
    collision |-> (!txOn && !driveLow));

  p_coll_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    collision |=> !collision);

  p_low_match_r9: assert property (@(posedge clk) disable iff (!rstN)
    (bitEn && txOn && driveLow) |=> !collision);

  p_done_release_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!txOn && !collision));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

bind hdlc_bus_arbiter hdlc_arb_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .bitEn     (bitEn),
  .txReq     (txReq),
  .busSense  (busSense),
  .bitReady  (bitReady),
  .driveLow  (driveLow),
  .txOn      (txOn),
  .collision (collision),
  .done      (done)
);

// File: tb/hdlc_bus_arbiter_tb.sv
module hdlc_bus_arbiter_tb;

  localparam int CLK_PERIOD = 10;
  localparam int BIT_DIV    = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitEn = 1'b0;
  logic txReq = 1'b0;
  logic txBit = 1'b1;
  logic txLast = 1'b0;
  logic otherLow = 1'b0;
  logic bitReady, driveLow, txOn, collision, done, busSense;

  // wired-AND line: either station may pull it low
  assign busSense = !(driveLow || otherLow);

  hdlc_bus_arbiter u_dut (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .txReq(txReq),
    .txBit(txBit), .txLast(txLast), .bitReady(bitReady),
    .busSense(busSense), .driveLow(driveLow), .txOn(txOn),
    .collision(collision), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int compared = 0;
  int mismatched = 0;

  typedef struct { int kind; logic val; } item_t;  // kind 0 bit, 1 coll, 2 done
  item_t expQ[$];
  bit idleQ[$];
  bit frameQ[$];
  bit compQ[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // bit-strobe generator, updated away from both clock edges
  initial begin
    int div = 0;
    forever begin
      @(posedge clk); #2;
      div = (div + 1) % BIT_DIV;
      bitEn = (div == 0) && rstN;
    end
  end

  task automatic observe(input int kind, input logic val);
    item_t it;
    string tag;
    tag = (kind == 0) ? "R6 R7 bit" : (kind == 1) ? "R8 collision" : "R10 done";
    if (expQ.size() == 0) begin
      check(1'b0, {tag, " unexpected"}, kind, -1);
    end else begin
      it = expQ.pop_front();
      check(it.kind == kind && it.val == val, tag, kind * 2 + val, it.kind * 2 + it.val);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (bitEn && txOn) observe(0, !driveLow);
      if (collision) observe(1, 1'b0);
      if (done) observe(2, 1'b0);
    end
  end

  function automatic int calcWait(input int need);
    int cnt = 0;
    for (int s = 0; s < 1000; s++) begin
      bit lvl = (s < idleQ.size()) ? idleQ[s] : 1'b1;
      cnt = lvl ? cnt + 1 : 0;
      if (cnt >= need) return s + 1;
    end
    return -1;
  endfunction

  task automatic runFrame(input int expWait, input string waitTag, output bit collided);
    int len = frameQ.size();
    int idx = 0;
    int w = 0;
    bit fin = 0;
    bit preRdy, preOn;
    item_t it;
    collided = 0;
    // expected scoreboard items
    for (int k = 0; k < len; k++) begin
      it.kind = 0; it.val = frameQ[k]; expQ.push_back(it);
      if (frameQ[k] && !compQ[k]) begin
        it.kind = 1; it.val = 1'b0; expQ.push_back(it);
        break;
      end
      if (k == len - 1) begin
        it.kind = 2; it.val = 1'b0; expQ.push_back(it);
      end
    end
    txReq = 1'b1;
    txBit = frameQ[0];
    txLast = (len == 1);
    otherLow = (idleQ.size() > 0) ? !idleQ[0] : 1'b0;
    while (!fin) begin
      do @(negedge clk); while (!bitEn);
      preRdy = bitReady;
      preOn = txOn;
      @(posedge clk); #1;
      if (preRdy) begin
        idx++;
        if (idx < len) begin
          txBit = frameQ[idx];
          txLast = (idx == len - 1);
        end
      end
      if (!preOn) begin
        w++;
        if (txOn) begin
          check(w == expWait, {waitTag, " idle wait"}, w, expWait);
          otherLow = !compQ[idx-1];
        end else begin
          otherLow = (w < idleQ.size()) ? !idleQ[w] : 1'b0;
        end
      end else begin
        if (collision) begin
          collided = 1; fin = 1;
        end else if (done) begin
          fin = 1; txReq = 1'b0;
        end else begin
          otherLow = !compQ[idx-1];
        end
        if (fin) begin
          otherLow = 1'b0;
          check(!txOn && !driveLow, collided ? "R8 release" : "R10 release",
                int'(txOn) * 2 + int'(driveLow), 0);
        end
      end
    end
    @(negedge clk); #1;
    check(expQ.size() == 0, "R8 R10 frame items left", expQ.size(), 0);
  endtask

  // watchdog
  initial begin
    #(CLK_PERIOD * 150000);
    mismatched++;
    $display("FAIL watchdog: run hung");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    bit c;
    // R1 reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!driveLow && !txOn && !collision && !done && !bitReady, "R1 in reset",
          int'(driveLow) + int'(txOn) + int'(collision) + int'(done), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!driveLow && !txOn && !collision && !done && !bitReady, "R1 after reset",
          int'(driveLow) + int'(txOn) + int'(collision) + int'(done), 0);

    // R2 no request: line must stay released
    for (int s = 0; s < 12; s++) begin
      do @(negedge clk); while (!bitEn);
      @(posedge clk); #1;
      check(!txOn && !driveLow, "R2 idle without request",
            int'(txOn) * 2 + int'(driveLow), 0);
    end

    // R3 line already idle long enough: starts on first strobe
    idleQ = {};
    frameQ = '{0, 1, 1, 0, 1, 0};
    compQ  = '{1, 1, 1, 1, 1, 1};
    runFrame(1, "R3 saturated", c);
    check(!c, "R10 frame A completes", int'(c), 0);

    // R5 own success: 10-count next
    frameQ = '{1, 0, 1};
    compQ  = '{1, 1, 1};
    runFrame(10, "R5 back-off", c);
    check(!c, "R10 frame B completes", int'(c), 0);

    // R5 again, then R9 matching low and R8 lost arbitration mid-frame
    frameQ = '{0, 1, 1, 0};
    compQ  = '{0, 1, 0, 1};
    runFrame(10, "R5 back-off again", c);
    check(c, "R8 frame C collides", int'(c), 1);

    // R11 retry after collision, plain 8-count (R3)
    compQ = '{1, 1, 1, 1};
    runFrame(8, "R11 R3 retry", c);
    check(!c, "R11 retry completes", int'(c), 0);

    // R4 low sample during 10-count restarts it
    idleQ  = '{1, 1, 1, 1, 1, 1, 0};
    frameQ = '{1, 1, 0, 1, 0, 0, 1};
    compQ  = '{1, 1, 0, 1, 1, 0, 1};
    runFrame(calcWait(10), "R4 R5 restart", c);
    check(!c, "R9 frame D completes", int'(c), 0);

    // R8 single-bit frame loses
    idleQ  = '{0, 1, 1, 0};
    frameQ = '{1};
    compQ  = '{0};
    runFrame(calcWait(10), "R4 single", c);
    check(c, "R8 single-bit collides", int'(c), 1);

    // R11 retry with restarted count
    idleQ  = '{1, 1, 1, 1, 1, 0, 1, 1};
    compQ  = '{1};
    runFrame(calcWait(8), "R11 R4 retry", c);
    check(!c, "R11 single-bit completes", int'(c), 0);

    // R2 after release, nothing more is driven
    idleQ = {};
    for (int s = 0; s < 12; s++) begin
      do @(negedge clk); while (!bitEn);
      @(posedge clk); #1;
      check(!txOn && !driveLow, "R2 quiet after frames",
            int'(txOn) * 2 + int'(driveLow), 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule